// File: doc/BRIEF.md
# I2C Clock Phase Generator

This block produces the serial clock of an I2C master from cycle counts held in three 32-bit timing words. A command engine asks it for one of three operations (a START, one data bit, or a STOP) over a valid/ready handshake. The generator drives the clock line low or releases it, and it marks two points inside each bit. The transmit change strobe falls inside the low phase and tells the engine when to move the data line. The receive sample strobe falls inside the high phase and tells it when to capture the data line. After each START or bit the clock is parked low until the next command arrives. After a STOP the clock is released and the block stays busy for the bus-free time before it takes a new START.

Each phase length is a programmed count plus a fixed overhead: 2 cycles on the low phase and 7 on the high phase. The timing words are captured when a command is accepted, so software may rewrite them while a command is running. The high phase does not start counting until the released clock line reads back high, which lets a slave stretch the clock.

The controller is a single state machine with seven states. The states are IDLE (clock released, bus free), HOLD (clock released for the START hold count), PARK (clock held low between operations), LOW (counted low phase), WAIT_HI (clock released, waiting for the line to read high), HIGH (counted high phase) and BUS_FREE (clock released after a STOP). Its transitions are:

- IDLE→HOLD on an accepted START.
- HOLD→PARK at the end of the hold count.
- PARK→LOW on any accepted START, BIT or STOP.
- LOW→WAIT_HI at the end of the low count.
- WAIT_HI→HOLD (restart) or WAIT_HI→HIGH (bit, stop) once the line reads high.
- HIGH→PARK (bit) or HIGH→BUS_FREE (stop) at the end of the high count.
- BUS_FREE→IDLE at the end of the bus-free count.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset the clock is released (`scl_low`=0), `clk_busy`=0, `cmd_ready`=1, and `tx_change`, `rx_sample` and `op_done` are all 0.
- R2: `cmd_kind` encodes 0 = none, 1 = START, 2 = BIT, 3 = STOP. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high exactly in IDLE and PARK.
- R3: A START accepted in IDLE keeps the clock released for `timing_w2[15:0]` cycles, with a count of zero treated as one. `op_done` is high in the last of these cycles, and the clock is driven low from the next cycle on.
- R4: A BIT, STOP or repeated START accepted in PARK drives the clock low for `timing_w1[31:16]` + 2 cycles, counted from the first cycle after acceptance, and then releases it.
- R5: `tx_change` pulses once in the low phase, in the cycle whose index (the first low cycle is index 0) equals `timing_w1[15:0]`. It does not pulse when that offset is not less than the low phase length.
- R6: For a BIT, the high phase lasts `timing_w0[31:16]` + 7 cycles and begins in the cycle after the released line is first seen high. `op_done` is high in its last cycle, and the clock is driven low in the cycle after that.
- R7: `rx_sample` pulses only in the high phase of a BIT, at the index `timing_w0[15:0]` counted from 0. It does not pulse when that offset is not less than the high phase length.
- R8: While the clock is released after a low phase and `scl_in` reads low, the high-phase count does not start. Every later event moves by the number of stretched cycles.
- R9: A STOP runs a low phase and a high phase, then keeps the clock released for `timing_w2[31:16]` bus-free cycles with `op_done` in the last one. It then returns to IDLE.
- R10: During the bus-free time `cmd_ready` is 0, so a pending START is accepted only in the first IDLE cycle.
- R11: A START accepted in PARK runs a low phase, waits for the line to read high, keeps the clock released for the hold count with `op_done` in its last cycle, and then parks low.
- R12: `clk_busy` is 1 in every state except IDLE, including PARK and BUS_FREE.
- R13: The timing words are captured on command acceptance. Changing them later has no effect on the command in progress.
- R14: A BIT or STOP offered in IDLE, and a none command offered in IDLE or PARK, are consumed without changing the clock, the strobes or `clk_busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timing_w0 | input | 32 | High count [31:16], receive sample offset [15:0] |
| timing_w1 | input | 32 | Low count [31:16], transmit change offset [15:0] |
| timing_w2 | input | 32 | Bus-free count [31:16], START hold count [15:0] |
| cmd_valid | input | 1 | Command request |
| cmd_kind | input | 2 | Command code (see R2) |
| cmd_ready | output | 1 | Command can be accepted |
| scl_in | input | 1 | Clock line read back |
| scl_low | output | 1 | Drive clock line low when 1, release when 0 |
| tx_change | output | 1 | Data-change strobe inside the low phase |
| rx_sample | output | 1 | Data-sample strobe inside the high phase |
| op_done | output | 1 | Last cycle of the current command |
| clk_busy | output | 1 | Generator is outside IDLE |

## Verification
Bits are run with middle offsets, with offsets on the first and last cycle of a phase, and with offsets past the phase end. Together these separate an off-by-one in the counters from a missing compare. A bit with the clock held low by the slave for several cycles shows whether the high count waits for the line or starts on release. A STOP followed at once by a START, and a repeated START from PARK, exercise the bus-free deferral and the hold path through WAIT_HI. Ignored commands and timing words rewritten in mid-command show that nothing moves without an accepted command.

// File: rtl/scl_phase_pkg.sv
package scl_phase_pkg;

    localparam int unsigned TG_FIELD_W = 16;
    localparam int unsigned TG_LEN_W   = TG_FIELD_W + 1;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_START = 2'd1,
        OP_BIT   = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_PARK,
        ST_LOW,
        ST_WAIT_HI,
        ST_HIGH,
        ST_BUS_FREE
    } phase_e;

    typedef struct packed {
        logic [TG_LEN_W-1:0] low_len;
        logic [TG_LEN_W-1:0] high_len;
        logic [TG_LEN_W-1:0] hold_len;
        logic [TG_LEN_W-1:0] free_len;
        logic [TG_LEN_W-1:0] tx_ofs;
        logic [TG_LEN_W-1:0] rx_ofs;
    } phase_cfg_t;

endpackage

// File: rtl/scl_cfg_capture.sv
module scl_cfg_capture
    import scl_phase_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned NUM_WORDS  = 3,
    parameter int unsigned LOW_EXTRA  = 2,
    parameter int unsigned HIGH_EXTRA = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    output phase_cfg_t        cfg
);

    localparam int unsigned HALF_W = WORD_W / 2;

    logic [WORD_W-1:0] word_in [NUM_WORDS];
    logic [WORD_W-1:0] word_q  [NUM_WORDS];

    assign word_in[0] = word0;
    assign word_in[1] = word1;
    assign word_in[2] = word2;

    // one capture register per timing word, loaded on command acceptance
    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[gi] <= '0;
            end else if (load) begin
                word_q[gi] <= word_in[gi];
            end
        end
    end

    function automatic logic [TG_LEN_W-1:0] widen(input logic [HALF_W-1:0] f);
        return TG_LEN_W'(f);
    endfunction

    always_comb begin
        cfg.high_len = widen(word_q[0][WORD_W-1:HALF_W]) + TG_LEN_W'(HIGH_EXTRA);
        cfg.rx_ofs   = widen(word_q[0][HALF_W-1:0]);
        cfg.low_len  = widen(word_q[1][WORD_W-1:HALF_W]) + TG_LEN_W'(LOW_EXTRA);
        cfg.tx_ofs   = widen(word_q[1][HALF_W-1:0]);
        cfg.free_len = widen(word_q[2][WORD_W-1:HALF_W]);
        cfg.hold_len = widen(word_q[2][HALF_W-1:0]);
    end

endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int unsigned LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [LEN_W-1:0] len,
    input  logic [LEN_W-1:0] ofs,
    output logic             last,
    output logic             at_ofs
);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + {{LEN_W{1'b0}}, 1'b1};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next[LEN_W-1:0];
        end
    end

    // a zero length behaves as a length of one
    assign last   = (cnt_next >= {1'b0, len});
    assign at_ofs = (cnt_q == ofs);

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_phase_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned LOW_EXTRA  = 2,
    parameter int unsigned HIGH_EXTRA = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] timing_w0,
    input  logic [WORD_W-1:0] timing_w1,
    input  logic [WORD_W-1:0] timing_w2,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    output logic              cmd_ready,
    input  logic              scl_in,
    output logic              scl_low,
    output logic              tx_change,
    output logic              rx_sample,
    output logic              op_done,
    output logic              clk_busy
);

    phase_e     state_q, state_d;
    op_e        op_q;
    phase_cfg_t cfg;
    logic       accept;
    logic       cnt_clear, cnt_last, cnt_at_ofs;
    logic       timed;
    logic [TG_LEN_W-1:0] cur_len, cur_ofs;

    assign accept = cmd_valid && cmd_ready;

    scl_cfg_capture #(
        .WORD_W    (WORD_W),
        .NUM_WORDS (3),
        .LOW_EXTRA (LOW_EXTRA),
        .HIGH_EXTRA(HIGH_EXTRA)
    ) cfg_i (
        .clk  (clk),
        .rst_n(rst_n),
        .load (accept),
        .word0(timing_w0),
        .word1(timing_w1),
        .word2(timing_w2),
        .cfg  (cfg)
    );

    // length and strobe offset of the phase now running
    always_comb begin
        cur_len = '0;
        cur_ofs = '1;
        timed   = 1'b0;
        unique case (state_q)
            ST_LOW:      begin cur_len = cfg.low_len;  cur_ofs = cfg.tx_ofs; timed = 1'b1; end
            ST_HIGH:     begin cur_len = cfg.high_len; cur_ofs = cfg.rx_ofs; timed = 1'b1; end
            ST_HOLD:     begin cur_len = cfg.hold_len; timed = 1'b1; end
            ST_BUS_FREE: begin cur_len = cfg.free_len; timed = 1'b1; end
            default:     begin end
        endcase
    end

    assign cnt_clear = !timed || cnt_last;

    scl_phase_counter #(
        .LEN_W(TG_LEN_W)
    ) cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .len   (cur_len),
        .ofs   (cur_ofs),
        .last  (cnt_last),
        .at_ofs(cnt_at_ofs)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operation register, loaded with every accepted command
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_NONE;
        end else if (accept) begin
            op_q <= op_e'(cmd_kind);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && op_e'(cmd_kind) == OP_START) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (cnt_last) state_d = ST_PARK;
            end
            ST_PARK: begin
                if (accept && op_e'(cmd_kind) != OP_NONE) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (cnt_last) state_d = ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                if (scl_in) state_d = (op_q == OP_START) ? ST_HOLD : ST_HIGH;
            end
            ST_HIGH: begin
                if (cnt_last) state_d = (op_q == OP_STOP) ? ST_BUS_FREE : ST_PARK;
            end
            ST_BUS_FREE: begin
                if (cnt_last) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cmd_ready = 1'b0;
        scl_low   = 1'b0;
        tx_change = 1'b0;
        rx_sample = 1'b0;
        op_done   = 1'b0;
        clk_busy  = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                clk_busy  = 1'b0;
            end
            ST_HOLD: begin
                op_done = cnt_last;
            end
            ST_PARK: begin
                cmd_ready = 1'b1;
                scl_low   = 1'b1;
            end
            ST_LOW: begin
                scl_low   = 1'b1;
                tx_change = cnt_at_ofs;
            end
            ST_WAIT_HI: begin
            end
            ST_HIGH: begin
                rx_sample = cnt_at_ofs && (op_q == OP_BIT);
                op_done   = cnt_last && (op_q == OP_BIT);
            end
            ST_BUS_FREE: begin
                op_done = cnt_last;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk
    import scl_phase_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cmd_ready,
    input logic   scl_in,
    input logic   scl_low,
    input logic   tx_change,
    input logic   rx_sample,
    input logic   op_done,
    input logic   clk_busy,
    input phase_e state_q,
    input op_e    op_q
);

    // R5: the change strobe only appears while the clock is held low
    assert_tx_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_change |-> scl_low);

    // R7: the sample strobe belongs to a released clock during a data bit
    assert_rx_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_sample |-> (!scl_low && op_q == OP_BIT));

    // R7: the two strobes never coincide
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_change, rx_sample}));

    // R8: a line held low keeps the generator waiting
    assert_stretch_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_HI && !scl_in) |=> (state_q == ST_WAIT_HI));

    // R3: completion always lands in a resting state
    assert_done_rests_R3: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> (state_q == ST_PARK || state_q == ST_IDLE));

    // R10: no command is taken and the clock stays released during bus-free time
    assert_free_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUS_FREE) |-> (!cmd_ready && !scl_low));

    // R12: an idle generator is always ready
    assert_idle_ready_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_busy |-> cmd_ready);

endmodule

bind scl_phase_gen scl_phase_gen_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_ready(cmd_ready),
    .scl_in   (scl_in),
    .scl_low  (scl_low),
    .tx_change(tx_change),
    .rx_sample(rx_sample),
    .op_done  (op_done),
    .clk_busy (clk_busy),
    .state_q  (state_q),
    .op_q     (op_q)
);

// File: tb/scl_phase_gen_tb_top.sv
`timescale 1ns/1ps
module scl_phase_gen_tb_top;

    localparam int EV_TX = 0, EV_RX = 1, EV_REL = 2, EV_PULL = 3,
                   EV_DONE = 4, EV_FREE = 5, EV_ACC = 6;

    typedef struct {
        int    kind;
        int    rel;
        string tag;
    } ev_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] timing_w0 = '0, timing_w1 = '0, timing_w2 = '0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd0;
    logic        stretch = 1'b0;
    logic        cmd_ready, scl_in, scl_low, tx_change, rx_sample, op_done, clk_busy;

    int checks = 0;
    int errors = 0;
    ev_t exp_q[$];

    always #5 clk = ~clk;

    assign scl_in = !(scl_low || stretch);

    scl_phase_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .timing_w0(timing_w0),
        .timing_w1(timing_w1),
        .timing_w2(timing_w2),
        .cmd_valid(cmd_valid),
        .cmd_kind (cmd_kind),
        .cmd_ready(cmd_ready),
        .scl_in   (scl_in),
        .scl_low  (scl_low),
        .tx_change(tx_change),
        .rx_sample(rx_sample),
        .op_done  (op_done),
        .clk_busy (clk_busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input int rel, input string tag);
        ev_t e;
        e.kind = kind;
        e.rel  = rel;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    task automatic got(input int kind, input int rel);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected event kind %0d rel %0d (none expected)", kind, rel);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || (e.rel >= 0 && e.rel != rel)) begin
                errors++;
                $display("FAIL %s event kind/rel actual %0d/%0d expected %0d/%0d",
                         e.tag, kind, rel, e.kind, e.rel);
            end
        end
    endtask

    // monitor: timestamps every output event relative to the last acceptance
    int rel = 0;
    bit acc_pend = 1'b0, prev_low = 1'b0, prev_busy = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            rel = 0;
            acc_pend = 1'b0;
        end else begin
            if (acc_pend) rel = 0; else rel++;
            if (tx_change)              got(EV_TX, rel);
            if (rx_sample)              got(EV_RX, rel);
            if (prev_low && !scl_low)   got(EV_REL, rel);
            if (!prev_low && scl_low)   got(EV_PULL, rel);
            if (op_done)                got(EV_DONE, rel);
            if (prev_busy && !clk_busy) got(EV_FREE, rel);
            if (cmd_valid && cmd_ready) got(EV_ACC, rel);
            acc_pend = cmd_valid && cmd_ready;
        end
        prev_low  = scl_low;
        prev_busy = clk_busy;
    end

    task automatic set_words(input int lo, input int xo, input int hi, input int ro,
                             input int ld, input int bf);
        timing_w0 = {16'(hi), 16'(ro)};
        timing_w1 = {16'(lo), 16'(xo)};
        timing_w2 = {16'(bf), 16'(ld)};
    endtask

    // returns in the first cycle after the accepting edge (rel 0)
    task automatic issue(input int kind);
        @(posedge clk); #1;
        cmd_valid = 1'b1;
        cmd_kind  = 2'(kind);
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        cmd_kind  = 2'd0;
    endtask

    task automatic wait_ready();
        forever begin
            @(negedge clk);
            if (cmd_ready) break;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        set_words(4, 1, 3, 2, 3, 5);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(scl_low == 1'b0, "R1 scl_low", scl_low, 0);
        chk(clk_busy == 1'b0, "R1 clk_busy", clk_busy, 0);
        chk(cmd_ready == 1'b1, "R1 cmd_ready", cmd_ready, 1);
        chk({tx_change, rx_sample, op_done} == 3'b000, "R1 strobes",
            {tx_change, rx_sample, op_done}, 0);

        // R14: BIT in idle is consumed without effect
        push(EV_ACC, -1, "R14");
        issue(2);
        repeat (5) @(negedge clk);
        chk(clk_busy == 1'b0, "R14 busy after idle BIT", clk_busy, 0);
        chk(scl_low == 1'b0, "R14 clock after idle BIT", scl_low, 0);

        // R3: START from idle, hold 3
        push(EV_ACC, -1, "R3");
        push(EV_DONE, 2, "R3 hold end");
        push(EV_PULL, 3, "R3 park");
        issue(1);
        wait_ready();
        // R2, R12 parked state
        chk(cmd_ready == 1'b1, "R2 ready parked", cmd_ready, 1);
        chk(clk_busy == 1'b1, "R12 busy parked", clk_busy, 1);

        // R4..R7 nominal bit: L=4 X=1 H=3 R=2
        push(EV_ACC, -1, "R4");
        push(EV_TX, 1, "R5 tx offset");
        push(EV_REL, 6, "R4 low length");
        push(EV_RX, 9, "R7 rx offset");
        push(EV_DONE, 16, "R6 high length");
        push(EV_PULL, 17, "R6 park");
        issue(2);
        wait_ready();

        // R8 stretch by 4 with boundary offsets X=0 R=H+6
        set_words(4, 0, 3, 9, 3, 5);
        stretch = 1'b1;
        push(EV_ACC, -1, "R8");
        push(EV_TX, 0, "R5 first cycle");
        push(EV_REL, 6, "R8 release");
        push(EV_RX, 20, "R7 last cycle stretched");
        push(EV_DONE, 20, "R8 stretched done");
        push(EV_PULL, 21, "R8 stretched park");
        issue(2);
        repeat (4 + 2 + 4) @(posedge clk);
        #1 stretch = 1'b0;
        wait_ready();

        // R5/R7 offsets past phase end: no strobes
        set_words(4, 6, 3, 10, 3, 5);
        push(EV_ACC, -1, "R5");
        push(EV_REL, 6, "R5 no tx");
        push(EV_DONE, 16, "R7 no rx");
        push(EV_PULL, 17, "R7 park");
        issue(2);
        wait_ready();

        // R14: none command while parked
        push(EV_ACC, -1, "R14 none");
        issue(0);
        repeat (4) @(negedge clk);
        chk(scl_low == 1'b1, "R14 still parked", scl_low, 1);
        chk(clk_busy == 1'b1, "R14 busy unchanged", clk_busy, 1);

        // R13: words rewritten after acceptance
        set_words(4, 1, 3, 2, 3, 5);
        push(EV_ACC, -1, "R13");
        push(EV_TX, 1, "R13 tx");
        push(EV_REL, 6, "R13 low kept");
        push(EV_RX, 9, "R13 rx kept");
        push(EV_DONE, 16, "R13 high kept");
        push(EV_PULL, 17, "R13 park");
        issue(2);
        set_words(20, 9, 20, 9, 3, 5);
        wait_ready();
        set_words(4, 1, 3, 2, 3, 5);

        // R11 repeated start from park
        push(EV_ACC, -1, "R11");
        push(EV_TX, 1, "R11 tx");
        push(EV_REL, 6, "R11 release");
        push(EV_DONE, 9, "R11 hold end");
        push(EV_PULL, 10, "R11 park");
        issue(1);
        wait_ready();

        // R9 stop, R10 start deferred to first idle cycle
        push(EV_ACC, -1, "R9");
        push(EV_TX, 1, "R9 tx");
        push(EV_REL, 6, "R9 release");
        push(EV_DONE, 21, "R9 bus free end");
        push(EV_FREE, 22, "R9 idle");
        push(EV_ACC, 22, "R10 deferred accept");
        push(EV_DONE, 2, "R10 hold end");
        push(EV_PULL, 3, "R10 park");
        issue(3);
        repeat (18) @(posedge clk);
        @(negedge clk);
        chk(cmd_ready == 1'b0, "R10 not ready in bus free", cmd_ready, 0);
        chk(clk_busy == 1'b1, "R12 busy in bus free", clk_busy, 1);
        chk(scl_low == 1'b0, "R9 released in bus free", scl_low, 0);
        issue(1);
        wait_ready();

        // R3 zero hold count behaves as one
        push(EV_ACC, -1, "R9 second stop");
        push(EV_TX, 1, "R9 tx");
        push(EV_REL, 6, "R9 release");
        push(EV_DONE, 21, "R9 bus free end");
        push(EV_FREE, 22, "R9 idle");
        push(EV_ACC, 22, "R10 accept");
        push(EV_DONE, 0, "R3 zero hold");
        push(EV_PULL, 1, "R3 zero hold park");
        issue(3);
        set_words(4, 1, 3, 2, 0, 5);
        issue(1);
        repeat (10) @(negedge clk);

        chk(exp_q.size() == 0, "R9 all expected events seen", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule